// File: doc/BRIEF.md
# Opcode-Snooping Bank Select Latch

This block sits beside an 8-bit processor and watches its bus. Two opcodes that the processor executes as two-byte no-operation instructions are set aside as bank-load commands. When the processor fetches one of them, the block takes the operand byte that follows on the data bus and keeps its low bits in one of two bank registers. Opcode 0x22 loads the register for the lower window and opcode 0x42 loads the register for the upper window.

The lower 32 KB of the processor address space is split into two 16 KB windows. Each window is extended independently by its own bank register into a larger physical RAM. The block combines the current address with the stored banks and reports, for every access, the extra physical address bits and whether the access falls in a banked window at all.

Top module: `bank_snoop_latch`

## Requirements
- R1: After reset both bank registers hold zero, so an access below 0x8000 reports bank zero.
- R2: A cycle with sync high, rw high (read) and data 0x22 arms a load; on the next clock edge the low 6 bits of the data bus are stored as the lower-window bank.
- R3: A cycle with sync high, rw high and data 0x42 arms a load; on the next clock edge the low 6 bits of the data bus are stored as the upper-window bank.
- R4: For addresses 0x0000 to 0x3FFF (addr[15]=0, addr[14]=0) bank_out shows the lower-window bank; for 0x4000 to 0x7FFF (addr[14]=1) it shows the upper-window bank, and banked is 1.
- R5: For addresses 0x8000 and above (addr[15]=1) banked is 0 and bank_out is zero.
- R6: A reserved opcode value seen while sync is low loads nothing and leaves both banks unchanged.
- R7: A reserved opcode value seen with sync high but rw low (write) loads nothing.
- R8: The operand is captured on the cycle after the opcode whatever the level of sync on that cycle; any other opcode value arms nothing.
- R9: Operand bits 7 and 6 are discarded, and a load into one bank leaves the other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-phase clock; the bus is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sync | input | 1 | High on an opcode fetch cycle |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 16 | Processor address of the current cycle |
| data | input | 8 | Processor data bus of the current cycle |
| bank_out | output | 6 | Physical bank bits for the current access |
| banked | output | 1 | 1 when the current access lies in a banked window |

## Verification
A wrong armed state shows up one clock later as a bank register that was loaded when it should not have been, or left alone when it should have been loaded, and it is visible at bank_out as soon as an address in the matching window is presented. A swapped window select or a missing upper-address qualifier shows up combinationally, in the same cycle, as the wrong bank value or a wrong banked flag. Stray loads from data cycles and write cycles are therefore probed by reading both windows right after the suspect cycle.

// File: rtl/bank_snoop_latch.sv
module bank_snoop_latch #(
  parameter int          BANK_W = 6,
  parameter int          ADDR_W = 16,
  parameter int          DATA_W = 8,
  parameter logic [7:0]  OP_LO  = 8'h22,
  parameter logic [7:0]  OP_HI  = 8'h42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync,
  input  logic              rw,
  input  logic [15:0]       addr,
  input  logic [7:0]        data,
  output logic [5:0]        bank_out,
  output logic              banked
);

  localparam int TOP_BIT = ADDR_W - 1;
  localparam int WIN_BIT = ADDR_W - 2;

  logic              fetch;
  logic              hit_lo, hit_hi;
  logic              pend_lo_q, pend_hi_q;
  logic [BANK_W-1:0] bank_lo_q, bank_hi_q;

  assign fetch  = sync && rw;
  assign hit_lo = fetch && (data == OP_LO);
  assign hit_hi = fetch && (data == OP_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_lo_q <= 1'b0;
      pend_hi_q <= 1'b0;
    end else begin
      pend_lo_q <= hit_lo;
      pend_hi_q <= hit_hi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_lo_q <= '0;
      bank_hi_q <= '0;
    end else begin
      if (pend_lo_q) bank_lo_q <= data[BANK_W-1:0];
      if (pend_hi_q) bank_hi_q <= data[BANK_W-1:0];
    end
  end

  assign banked   = !addr[TOP_BIT];
  assign bank_out = !banked ? '0 : (addr[WIN_BIT] ? bank_hi_q : bank_lo_q);

  AST_ARM_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && rw && data == OP_LO) |=> pend_lo_q);                       // R2
  AST_ARM_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && rw && data == OP_HI) |=> pend_hi_q);                       // R3
  AST_LOAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
    pend_lo_q |=> bank_lo_q == $past(data[BANK_W-1:0]));                // R8
  AST_LOAD_HI: assert property (@(posedge clk) disable iff (!rst_n)
    pend_hi_q |=> bank_hi_q == $past(data[BANK_W-1:0]));                // R8
  AST_HOLD_LO: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_lo_q |=> $stable(bank_lo_q));                                 // R6
  AST_HOLD_HI: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_hi_q |=> $stable(bank_hi_q));                                 // R9
  AST_ONE_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pend_lo_q, pend_hi_q}));                                  // R7

endmodule

// File: tb/bank_snoop_latch_tb.sv
module bank_snoop_latch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b0;
  logic        rw = 1'b1;
  logic [15:0] addr = 16'hFFFC;
  logic [7:0]  data = 8'hEA;
  logic [5:0]  bank_out;
  logic        banked;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  bank_snoop_latch u_dut (
    .clk(clk), .rst_n(rst_n), .sync(sync), .rw(rw),
    .addr(addr), .data(data), .bank_out(bank_out), .banked(banked)
  );

  always #4 clk = ~clk;

  task automatic bus(input logic s, input logic r, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    sync = s; rw = r; addr = a; data = d;
    @(posedge clk);
  endtask

  task automatic probe(input logic [15:0] a, input logic [5:0] exp_b, input logic exp_k, input string tag);
    @(negedge clk);
    sync = 1'b0; rw = 1'b1; addr = a; data = 8'hEA;
    #1;
    total++;
    if (bank_out !== exp_b || banked !== exp_k) begin
      bad++;
      $display("FAIL %s addr=%h bank_out=%h banked=%b expected bank_out=%h banked=%b",
               tag, a, bank_out, banked, exp_b, exp_k);
    end
  endtask

  task automatic t_reset;
    probe(16'h1000, 6'h00, 1'b1, "R1 low window after reset");
    probe(16'h5000, 6'h00, 1'b1, "R1 high window after reset");
  endtask

  task automatic t_load_lo;
    bus(1, 1, 16'h8100, 8'h22);
    bus(0, 1, 16'h8101, 8'h2D);
    probe(16'h0000, 6'h2D, 1'b1, "R2 lower bank loaded");
    probe(16'h3FFF, 6'h2D, 1'b1, "R4 lower window top edge");
    probe(16'h4000, 6'h00, 1'b1, "R9 upper bank untouched");
  endtask

  task automatic t_load_hi;
    bus(1, 1, 16'h8200, 8'h42);
    bus(0, 1, 16'h8201, 8'h15);
    probe(16'h4000, 6'h15, 1'b1, "R3 upper bank loaded");
    probe(16'h7FFF, 6'h15, 1'b1, "R4 upper window top edge");
    probe(16'h2000, 6'h2D, 1'b1, "R9 lower bank kept");
  endtask

  task automatic t_unbanked;
    probe(16'h8000, 6'h00, 1'b0, "R5 0x8000 unbanked");
    probe(16'hFFFF, 6'h00, 1'b0, "R5 0xFFFF unbanked");
  endtask

  task automatic t_upper_bits;
    bus(1, 1, 16'h8300, 8'h22);
    bus(0, 1, 16'h8301, 8'hFF);
    probe(16'h1234, 6'h3F, 1'b1, "R9 bits 7:6 dropped");
  endtask

  task automatic t_no_sync;
    bus(0, 1, 16'h8400, 8'h22);
    bus(0, 1, 16'h8401, 8'h07);
    probe(16'h1234, 6'h3F, 1'b1, "R6 data byte 0x22 ignored");
    bus(0, 1, 16'h8402, 8'h42);
    bus(0, 1, 16'h8403, 8'h07);
    probe(16'h4567, 6'h15, 1'b1, "R6 data byte 0x42 ignored");
  endtask

  task automatic t_write;
    bus(1, 0, 16'h0200, 8'h42);
    bus(0, 1, 16'h0201, 8'h07);
    probe(16'h4567, 6'h15, 1'b1, "R7 write cycle ignored");
  endtask

  task automatic t_sync_operand;
    bus(1, 1, 16'h8500, 8'h42);
    bus(1, 1, 16'h8501, 8'h09);
    probe(16'h6000, 6'h09, 1'b1, "R8 operand with sync high captured");
    bus(1, 1, 16'h8600, 8'hEA);
    bus(0, 1, 16'h8601, 8'h01);
    probe(16'h0100, 6'h3F, 1'b1, "R8 other opcode lower kept");
    probe(16'h6100, 6'h09, 1'b1, "R8 other opcode upper kept");
  endtask

  task automatic t_reset_again;
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    probe(16'h0100, 6'h00, 1'b1, "R1 lower cleared by reset");
    probe(16'h6100, 6'h00, 1'b1, "R1 upper cleared by reset");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load_lo();
    t_load_hi();
    t_unbanked();
    t_upper_bits();
    t_no_sync();
    t_write();
    t_sync_operand();
    t_reset_again();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule